// File: doc/BRIEF.md
# Per-Core Layer Barrier and Resume Controller

This controller sits inside one compute core of a multi-core neural-network accelerator. A dispatcher streams it instructions, each tagged with the layer it belongs to. The controller forwards the instructions of the current layer to the core's execution units through a start/done handshake. It counts the operations still in flight, and a layer-end marker instruction closes the layer.

Once the marker has been taken and every in-flight operation has reported done, the core raises a local barrier flag. It then stays parked until the chip-level controller answers with a global release. The release advances the core to the next layer. Release pulses that arrive at any other time have no effect.

For online reconfiguration, the chip-level controller can request a resume at any moment, supplying a recorded layer number. The core drops its in-flight bookkeeping and loads that layer number. It then consumes and discards any instruction tagged with an older layer, so that execution continues from the recorded point rather than from layer zero.

Top module: `core_layer_sync`

## Requirements
- R1: While reset is low and afterwards until the first instruction is presented, `local_sync`, `ins_ready` and `eu_start` are 0 and `cur_layer` is 0. The first presented instruction is not accepted; it moves the core into its running state at the next clock edge.
- R2: While running with the layer open and fewer than MAX_INFLIGHT operations outstanding, a valid instruction is accepted in the same cycle (`ins_ready` = 1) and issued in that cycle (`eu_start` = 1, `eu_op` = `ins_op`). This applies when the instruction has `ins_last` = 0 and a tag equal to `cur_layer`.
- R3: When MAX_INFLIGHT operations are outstanding, no further operation is issued and no such instruction is accepted until a done has been counted.
- R4: An instruction whose tag is lower than `cur_layer` is accepted and discarded without an `eu_start`, whether or not it is a marker. A stale marker does not close the layer.
- R5: An instruction whose tag is higher than `cur_layer` is never accepted.
- R6: A marker (`ins_last` = 1) with the current tag is accepted without being issued. After that, no instruction is accepted until the layer has been released.
- R7: `local_sync` rises at the second rising clock edge after the later of two edges: the edge that accepts the marker, and the edge that counts the last outstanding done.
- R8: While `local_sync` is high and `global_sync` is low, `local_sync` stays high and no instruction is accepted.
- R9: When `global_sync` is sampled high while `local_sync` is high, `local_sync` is low after that edge, `cur_layer` has increased by one, and instructions of the new layer are accepted.
- R10: A `global_sync` pulse sampled while `local_sync` is low leaves `cur_layer` and `local_sync` unchanged.
- R11: `restore_req` sampled at an edge clears `local_sync` and the outstanding count at that edge. At the following edge, `cur_layer` holds the `restore_layer` value given with the request, and the core is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Dispatcher presents an instruction |
| ins_ready | output | 1 | Instruction is consumed at this edge |
| ins_layer | input | LAYER_W | Layer tag of the instruction |
| ins_last | input | 1 | Instruction is the layer-end marker |
| ins_op | input | OP_W | Operation word for the execution units |
| eu_start | output | 1 | Start pulse to the execution units |
| eu_op | output | OP_W | Operation word issued with `eu_start` |
| eu_done | input | 1 | One outstanding operation has finished |
| local_sync | output | 1 | Core has finished the current layer |
| global_sync | input | 1 | Chip-level release to the next layer |
| restore_req | input | 1 | Resume from a recorded layer |
| restore_layer | input | LAYER_W | Layer number to resume from |
| cur_layer | output | LAYER_W | Layer currently executed |

## Verification
Acceptance, issue and discard are combinational, so the bench samples them in the same cycle it drives the instruction, one nanosecond after the inputs change at the falling edge. `local_sync` is registered and trails its cause by two edges: the edge that records the marker or zeroes the count, then the edge that moves the state machine. The bench therefore tracks when its own model of outstanding operations reaches zero and expects low, then high, on the next two samples. A release or a resume request changes `local_sync` at the next edge. A resume changes `cur_layer` one edge later still, and the checks sample exactly those cycles.

// File: rtl/core_sync_pkg.sv
// Shared types for the per-core layer barrier controller.
// Assumes nothing beyond a two-bit state encoding.
package core_sync_pkg;

    // Barrier controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_WAIT    = 2'd2,
        ST_RESTORE = 2'd3
    } sync_state_e;

    // Relation of an instruction tag to the current layer
    typedef enum logic [1:0] {
        TAG_STALE  = 2'd0,
        TAG_CUR    = 2'd1,
        TAG_FUTURE = 2'd2
    } tag_cls_e;

endpackage

// File: rtl/tag_classifier.sv
// Compares an instruction's layer tag with the current layer.
// Purely combinational; assumes both tags use the same width and no wrap.
module tag_classifier
    import core_sync_pkg::*;
#(
    parameter int LAYER_W = 8
) (
    input  logic [LAYER_W-1:0] tag,
    input  logic [LAYER_W-1:0] cur,
    output tag_cls_e           cls
);

    // Three-way compare of tag against current layer
    always_comb begin
        if (tag < cur)       cls = TAG_STALE;
        else if (tag == cur) cls = TAG_CUR;
        else                 cls = TAG_FUTURE;
    end

endmodule

// File: rtl/inflight_counter.sv
// Counts operations started but not yet reported done.
// Assumes inc is never asserted while full; a done with nothing in flight is dropped.
module inflight_counter #(
    parameter  int MAX_INFLIGHT = 4,
    localparam int CNT_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [CNT_W-1:0] cnt_q;
    logic             dec_eff;

    // A done only counts while something is in flight
    assign dec_eff = dec && (cnt_q != '0);

    // Outstanding-operation register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && !dec_eff) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_eff && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(MAX_INFLIGHT));
    assign empty = (cnt_q == '0);

endmodule

// File: rtl/layer_ctx_reg.sv
// Holds the current layer number and the resume point captured with a request.
// Assumes capture and apply come from the barrier FSM one cycle apart.
module layer_ctx_reg #(
    parameter int LAYER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LAYER_W-1:0] capture_val,
    input  logic               apply,
    input  logic               advance,
    output logic [LAYER_W-1:0] cur_layer
);

    logic [LAYER_W-1:0] hold_q;
    logic [LAYER_W-1:0] cur_q;

    // Latch the resume point when a request is seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= capture_val;
        end
    end

    // Current layer: load on resume, step on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (apply) begin
            cur_q <= hold_q;
        end else if (advance) begin
            cur_q <= cur_q + 1'b1;
        end
    end

    assign cur_layer = cur_q;

endmodule

// File: rtl/barrier_fsm.sv
// Sequences a core through run, barrier wait and resume.
// Assumes marker_acc and layer_empty come from registered or input-driven logic
// and that a resume request has priority over every other event.
module barrier_fsm
    import core_sync_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restore_req,
    input  logic        ins_valid,
    input  logic        marker_acc,
    input  logic        layer_empty,
    input  logic        global_sync,
    output sync_state_e state,
    output logic        marker_seen,
    output logic        local_sync,
    output logic        layer_advance,
    output logic        layer_apply
);

    sync_state_e state_q, state_d;
    logic        marker_q, marker_d;
    logic        lsync_q, lsync_d;
    logic        done_now;

    // Layer is finished once the marker is recorded and nothing is in flight
    assign done_now = marker_q && layer_empty;

    // Next-state and flag logic
    always_comb begin
        state_d  = state_q;
        marker_d = marker_q;
        lsync_d  = lsync_q;
        if (restore_req) begin
            state_d  = ST_RESTORE;
            marker_d = 1'b0;
            lsync_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ins_valid) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (done_now) begin
                        state_d  = ST_WAIT;
                        marker_d = 1'b0;
                        lsync_d  = 1'b1;
                    end else if (marker_acc) begin
                        marker_d = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (global_sync) begin
                        state_d = ST_RUN;
                        lsync_d = 1'b0;
                    end
                end
                ST_RESTORE: begin
                    state_d = ST_RUN;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            marker_q <= 1'b0;
            lsync_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            marker_q <= marker_d;
            lsync_q  <= lsync_d;
        end
    end

    assign state         = state_q;
    assign marker_seen   = marker_q;
    assign local_sync    = lsync_q;
    assign layer_advance = (state_q == ST_WAIT) && global_sync && !restore_req;
    assign layer_apply   = (state_q == ST_RESTORE);

endmodule

// File: rtl/core_layer_sync.sv
// Top of the per-core layer barrier and resume controller.
// Accepts tagged instructions, issues current-layer work to the execution
// units, raises a barrier flag at layer end and resumes from a supplied layer.
// Assumes execution units return exactly one done per start and that the
// chip-level controller drains stale dones before requesting a resume.
module core_layer_sync
    import core_sync_pkg::*;
#(
    parameter  int LAYER_W      = 8,
    parameter  int OP_W         = 16,
    parameter  int MAX_INFLIGHT = 4,
    localparam int CNT_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    output logic               ins_ready,
    input  logic [LAYER_W-1:0] ins_layer,
    input  logic               ins_last,
    input  logic [OP_W-1:0]    ins_op,
    output logic               eu_start,
    output logic [OP_W-1:0]    eu_op,
    input  logic               eu_done,
    output logic               local_sync,
    input  logic               global_sync,
    input  logic               restore_req,
    input  logic [LAYER_W-1:0] restore_layer,
    output logic [LAYER_W-1:0] cur_layer
);

    sync_state_e        state;
    tag_cls_e           cls;
    logic               marker_seen;
    logic               layer_advance;
    logic               layer_apply;
    logic               marker_acc;
    logic               take_ok;
    logic               cnt_full;
    logic               cnt_empty;
    logic [CNT_W-1:0]   inflight;
    logic [LAYER_W-1:0] layer_q;

    // Tag comparison against the current layer
    tag_classifier #(.LAYER_W(LAYER_W)) u_cls (
        .tag (ins_layer),
        .cur (layer_q),
        .cls (cls)
    );

    // Outstanding execution-unit operations
    inflight_counter #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restore_req),
        .inc   (eu_start),
        .dec   (eu_done),
        .count (inflight),
        .full  (cnt_full),
        .empty (cnt_empty)
    );

    // Current layer and resume point
    layer_ctx_reg #(.LAYER_W(LAYER_W)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (restore_req),
        .capture_val (restore_layer),
        .apply       (layer_apply),
        .advance     (layer_advance),
        .cur_layer   (layer_q)
    );

    // Run / barrier / resume sequencing
    barrier_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .restore_req   (restore_req),
        .ins_valid     (ins_valid),
        .marker_acc    (marker_acc),
        .layer_empty   (cnt_empty),
        .global_sync   (global_sync),
        .state         (state),
        .marker_seen   (marker_seen),
        .local_sync    (local_sync),
        .layer_advance (layer_advance),
        .layer_apply   (layer_apply)
    );

    // The layer is open to new instructions only while running before its marker
    assign take_ok = (state == ST_RUN) && !marker_seen && !restore_req;

    // Accept stale tags always, current markers always, current work when not full
    always_comb begin
        ins_ready = 1'b0;
        if (take_ok) begin
            unique case (cls)
                TAG_STALE:  ins_ready = 1'b1;
                TAG_CUR:    ins_ready = ins_last || !cnt_full;
                default:    ins_ready = 1'b0;
            endcase
        end
    end

    // Issue only current-layer work; markers and stale tags are swallowed
    assign eu_start   = ins_valid && ins_ready && (cls == TAG_CUR) && !ins_last;
    assign marker_acc = ins_valid && ins_ready && (cls == TAG_CUR) && ins_last;
    assign eu_op      = ins_op;
    assign cur_layer  = layer_q;

endmodule

// File: rtl/core_layer_sync_chk.sv
// Property checker for core_layer_sync, attached through bind.
// Assumes it observes the top-level ports plus the FSM state and in-flight count.
module core_layer_sync_chk
    import core_sync_pkg::*;
#(
    parameter  int LAYER_W      = 8,
    parameter  int MAX_INFLIGHT = 4,
    localparam int CNT_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic               ins_ready,
    input logic [LAYER_W-1:0] ins_layer,
    input logic               ins_last,
    input logic               eu_start,
    input logic               local_sync,
    input logic               global_sync,
    input logic               restore_req,
    input logic [LAYER_W-1:0] restore_layer,
    input logic [LAYER_W-1:0] cur_layer,
    input logic [CNT_W-1:0]   inflight,
    input sync_state_e        state
);

    // R2
    issue_is_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eu_start |-> (ins_valid && ins_ready && ins_layer == cur_layer && !ins_last));

    // R3
    no_issue_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == CNT_W'(MAX_INFLIGHT)) |-> !eu_start);

    // R4
    stale_not_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_layer < cur_layer) |-> !eu_start);

    // R5
    future_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_layer > cur_layer) |-> !ins_ready);

    // R6
    marker_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && ins_last && ins_layer == cur_layer && !restore_req)
        |=> !ins_ready);

    // R8
    barrier_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_sync && !global_sync && !restore_req) |=> (local_sync && !ins_ready));

    // R9
    release_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_sync && global_sync && !restore_req)
        |=> (!local_sync && cur_layer == LAYER_W'($past(cur_layer) + 1'b1)));

    // R10
    stray_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (global_sync && !local_sync && !restore_req && state != ST_RESTORE)
        |=> (cur_layer == $past(cur_layer) && !local_sync));

    // R11
    resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> (!local_sync && inflight == '0));

    // R11
    resume_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req ##1 !restore_req) |=> (cur_layer == $past(restore_layer, 2)));

endmodule

bind core_layer_sync core_layer_sync_chk #(
    .LAYER_W      (LAYER_W),
    .MAX_INFLIGHT (MAX_INFLIGHT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_layer     (ins_layer),
    .ins_last      (ins_last),
    .eu_start      (eu_start),
    .local_sync    (local_sync),
    .global_sync   (global_sync),
    .restore_req   (restore_req),
    .restore_layer (restore_layer),
    .cur_layer     (cur_layer),
    .inflight      (inflight),
    .state         (state)
);

// File: tb/core_layer_sync_tb.sv
// Self-checking bench for core_layer_sync: directed corners plus random layers.
module core_layer_sync_tb;

    localparam int LW = 8;
    localparam int OW = 16;
    localparam int MO = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ins_valid, ins_ready, ins_last;
    logic [LW-1:0] ins_layer;
    logic [OW-1:0] ins_op;
    logic          eu_start, eu_done;
    logic [OW-1:0] eu_op;
    logic          local_sync, global_sync, restore_req;
    logic [LW-1:0] restore_layer, cur_layer;

    int n_chk = 0;
    int n_bad = 0;
    int pend  = 0;
    int pend_b;
    bit auto_done = 1'b1;
    logic s_rdy, s_acc, s_st, s_ls;
    logic [OW-1:0] s_op;
    logic [LW-1:0] s_cur;

    always #5 clk = ~clk;

    core_layer_sync #(.LAYER_W(LW), .OP_W(OW), .MAX_INFLIGHT(MO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_layer(ins_layer),
        .ins_last(ins_last), .ins_op(ins_op),
        .eu_start(eu_start), .eu_op(eu_op), .eu_done(eu_done),
        .local_sync(local_sync), .global_sync(global_sync),
        .restore_req(restore_req), .restore_layer(restore_layer),
        .cur_layer(cur_layer)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample 1 ns later, update the unit model
    task automatic step(input logic v, input logic [LW-1:0] tag, input logic last,
                        input logic [OW-1:0] op, input logic gs, input logic rr,
                        input logic [LW-1:0] rl);
        @(negedge clk);
        ins_valid = v; ins_layer = tag; ins_last = last; ins_op = op;
        global_sync = gs; restore_req = rr; restore_layer = rl;
        eu_done = auto_done && (pend > 0) && ($urandom_range(2) == 0);
        #1;
        pend_b = pend;
        s_rdy = ins_ready; s_acc = v && ins_ready; s_st = eu_start;
        s_op = eu_op; s_ls = local_sync; s_cur = cur_layer;
        if (s_st) pend++;
        if (eu_done) pend--;
        if (pend_b == MO) check("R3 no start when full", int'(s_st), 0);
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    // Run one layer of k operations, close it, and optionally release it
    task automatic run_layer(input int L, input int k, input bit do_sync);
        int i = 0;
        int guard = 0;
        bit mdone = 1'b0;
        logic [OW-1:0] op = OW'($urandom);
        while (!mdone && guard < 500) begin
            guard++;
            if (i < k) begin
                step(1'b1, LW'(L), 1'b0, op, 1'b0, 1'b0, '0);
                if (pend_b < MO) begin
                    check("R2 accept", int'(s_acc), 1);
                    check("R2 start", int'(s_st), 1);
                    check("R2 op", int'(s_op), int'(op));
                end
                if (s_acc) begin i++; op = OW'($urandom); end
            end else begin
                step(1'b1, LW'(L), 1'b1, '0, 1'b0, 1'b0, '0);
                check("R6 marker accepted", int'(s_acc), 1);
                check("R6 marker not issued", int'(s_st), 0);
                mdone = 1'b1;
            end
        end
        guard = 0;
        while (pend != 0 && guard < 500) begin
            guard++;
            step(1'b1, LW'(L), 1'b0, '0, 1'b0, 1'b0, '0);
            check("R6 closed layer takes nothing", int'(s_acc), 0);
            check("R7 no early sync", int'(s_ls), 0);
        end
        idle();
        check("R7 sync low one edge after", int'(s_ls), 0);
        idle();
        check("R7 sync high two edges after", int'(s_ls), 1);
        if (do_sync) begin
            repeat ($urandom_range(3)) begin
                step(1'b1, LW'(L + 1), 1'b0, '0, 1'b0, 1'b0, '0);
                check("R8 sync held", int'(s_ls), 1);
                check("R8 nothing accepted", int'(s_acc), 0);
            end
            step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, '0);
            check("R8 sync before release", int'(s_ls), 1);
            idle();
            check("R9 sync dropped", int'(s_ls), 0);
            check("R9 layer advanced", int'(s_cur), (L + 1) % (1 << LW));
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; ins_valid = 1'b0; ins_layer = '0; ins_last = 1'b0; ins_op = '0;
        eu_done = 1'b0; global_sync = 1'b0; restore_req = 1'b0; restore_layer = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset local_sync", int'(local_sync), 0);
        check("R1 reset cur_layer", int'(cur_layer), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        check("R1 idle ready", int'(s_rdy), 0);
        check("R1 idle start", int'(s_st), 0);
        check("R1 idle local_sync", int'(s_ls), 0);
        // R10: stray release in idle
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, '0);
        idle();
        check("R10 idle release ignored layer", int'(s_cur), 0);
        check("R10 idle release ignored sync", int'(s_ls), 0);
        // R1: first instruction only wakes the core
        step(1'b1, '0, 1'b0, 16'h1234, 1'b0, 1'b0, '0);
        check("R1 first not accepted", int'(s_acc), 0);
        run_layer(0, 3, 1'b1);

        // R3 directed: fill the in-flight window with no dones
        auto_done = 1'b0;
        for (int j = 0; j < MO; j++) begin
            step(1'b1, LW'(1), 1'b0, OW'(16'h0A00 + j), 1'b0, 1'b0, '0);
            check("R2 fill accept", int'(s_acc), 1);
        end
        repeat (2) begin
            step(1'b1, LW'(1), 1'b0, 16'h0BBB, 1'b0, 1'b0, '0);
            check("R3 full not accepted", int'(s_acc), 0);
        end
        // R10: stray release while running
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, '0);
        idle();
        check("R10 run release ignored layer", int'(s_cur), 1);
        check("R10 run release ignored sync", int'(s_ls), 0);
        auto_done = 1'b1;
        run_layer(1, 2, 1'b0);

        // R11: resume while parked at the barrier
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, LW'(2));
        pend = 0;
        idle();
        check("R11 sync cleared", int'(s_ls), 0);
        idle();
        check("R11 layer loaded", int'(s_cur), 2);

        // R11: resume in the middle of a layer with work in flight
        auto_done = 1'b0;
        repeat (2) step(1'b1, LW'(2), 1'b0, 16'h0C0C, 1'b0, 1'b0, '0);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, LW'(5));
        pend = 0;
        idle();
        idle();
        check("R11 mid-layer layer loaded", int'(s_cur), 5);
        // R4: stale work and a stale marker are swallowed
        step(1'b1, LW'(3), 1'b0, 16'h0D0D, 1'b0, 1'b0, '0);
        check("R4 stale accepted", int'(s_acc), 1);
        check("R4 stale not issued", int'(s_st), 0);
        step(1'b1, LW'(4), 1'b1, '0, 1'b0, 1'b0, '0);
        check("R4 stale marker accepted", int'(s_acc), 1);
        check("R4 stale marker not issued", int'(s_st), 0);
        // R5: future tag waits
        step(1'b1, LW'(7), 1'b0, 16'h0E0E, 1'b0, 1'b0, '0);
        check("R5 future not accepted", int'(s_acc), 0);
        idle();
        check("R4 stale marker left layer open", int'(s_ls), 0);
        auto_done = 1'b1;
        run_layer(5, 4, 1'b1);

        // Random layers
        for (int L = 6; L < 26; L++) begin
            run_layer(L, $urandom_range(1, 6), 1'b1);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule